// File: doc/BRIEF.md
# Selectable Output Sample Coder

This block sits at the digital output of a data converter. It accepts unsigned offset-binary samples with a valid strobe and re-codes each one into two's complement, Gray code or plain offset binary. It registers the result, so the coded sample appears one cycle after it is accepted. A single 8-bit configuration register holds two one-hot fields. The low field picks the coding. The high field picks the physical output drive mode, which the block only decodes and passes on to the pad logic.

When a field is zero, or holds a value that is not one of its one-hot codes, the setting comes from a decoded three-level strap input instead. A nonzero one-hot register value always wins over the strap. A hard reset clears the register, which hands control back to the straps. A soft reset only flushes the output stage and leaves the register as it was.

Top module: `sample_coder`

## Requirements
- R1: While hard reset (`rst_n` low) is asserted, `out_valid` is 0, `out_sample` is 0 and both register fields are 000.
- R2: With format field `cfg_wdata[2:0]` = 001, the output is the input with its MSB inverted (two's complement).
- R3: With format field 010, the output is Gray code g = b XOR (b >> 1).
- R4: With format field 100, the output equals the input (offset binary).
- R5: With format field 000 or any non-one-hot value, the coding follows `fmt_strap`: 00 gives offset binary, 01 gives two's complement, 10 gives Gray code, 11 gives offset binary.
- R6: `out_mode` is coded 00 = LVDS 2 mA, 01 = LVDS 3 mA, 10 = LVCMOS and never takes the value 11. Mode field `cfg_wdata[7:5]` = 001 gives 00, 010 gives 01 and 100 gives 10.
- R7: With mode field 000 or any non-one-hot value, `out_mode` follows `mode_strap`: 00 gives 00, 01 gives 01, 10 gives 10, 11 gives 00.
- R8: `out_valid` equals `in_valid` delayed by one cycle. A sample presented with `in_valid` high appears coded on `out_sample` one cycle later, and `out_sample` holds its value when `in_valid` is low.
- R9: A synchronous soft reset (`soft_rst_n` low) clears `out_valid` and `out_sample` at the next edge and leaves both register fields unchanged.
- R10: A register write applies to samples presented in later cycles. A sample presented in the same cycle as the write is coded with the previous setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst_n | input | 1 | Synchronous soft reset, active low; register kept |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Register data: [7:5] mode field, [2:0] format field |
| fmt_strap | input | 2 | Decoded three-level format strap |
| mode_strap | input | 2 | Decoded three-level output-mode strap |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | SAMPLE_W (10) | Offset-binary input sample |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | SAMPLE_W (10) | Coded output sample |
| out_mode | output | 2 | Decoded output drive mode |

## Verification
The assertions check the following on every cycle: the one-cycle valid delay, that the output holds when no sample is presented, that two's-complement and Gray outputs match the sample accepted one cycle earlier, that the mode code never reaches 11, and that the register stays unchanged through a soft reset. Only the bench scenarios show the rest. These are the strap mapping for every strap value, the fallback for non-one-hot fields, the register taking precedence over the strap, and the exact cycle in which a new format takes effect relative to a sample presented alongside the write.

// File: rtl/sample_coder_pkg.sv
package sample_coder_pkg;
   typedef enum logic [1:0] {
      FMT_OFFSET = 2'd0,
      FMT_TWOS   = 2'd1,
      FMT_GRAY   = 2'd2
   } fmt_e;

   localparam logic [1:0] MODE_LVDS_LO = 2'd0;
   localparam logic [1:0] MODE_LVDS_HI = 2'd1;
   localparam logic [1:0] MODE_CMOS    = 2'd2;

   localparam int FIELD_W = 3;
   localparam int CODE_W  = 2;
endpackage

// File: rtl/sc_cfg_reg.sv
module sc_cfg_reg
   import sample_coder_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int FMT_LSB  = 0,
   parameter int MODE_LSB = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [DATA_W-1:0]  wdata,
   output logic [FIELD_W-1:0] fmt_field,
   output logic [FIELD_W-1:0] mode_field
);
   if (FMT_LSB + FIELD_W > DATA_W || MODE_LSB + FIELD_W > DATA_W) begin : g_bad_layout
      $error("sc_cfg_reg: field does not fit in register");
   end

   // hard reset only: the soft reset does not reach this register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_field  <= '0;
         mode_field <= '0;
      end else if (we) begin
         fmt_field  <= wdata[FMT_LSB +: FIELD_W];
         mode_field <= wdata[MODE_LSB +: FIELD_W];
      end
   end
endmodule

// File: rtl/sc_field_sel.sv
module sc_field_sel
   import sample_coder_pkg::*;
#(
   parameter logic [CODE_W-1:0] CODE_B0 = 2'd0,
   parameter logic [CODE_W-1:0] CODE_B1 = 2'd1,
   parameter logic [CODE_W-1:0] CODE_B2 = 2'd2
) (
   input  logic [FIELD_W-1:0] field,
   input  logic [1:0]         strap,
   output logic [CODE_W-1:0]  code
);
   logic [CODE_W-1:0] strap_code;

   // three-level strap: low, mid, high; the unused code falls back to the low setting
   always_comb begin
      case (strap)
         2'b01:   strap_code = 2'd1;
         2'b10:   strap_code = 2'd2;
         default: strap_code = 2'd0;
      endcase
   end

   always_comb begin
      case (field)
         3'b001:  code = CODE_B0;
         3'b010:  code = CODE_B1;
         3'b100:  code = CODE_B2;
         default: code = strap_code;
      endcase
   end
endmodule

// File: rtl/sc_recode.sv
module sc_recode
   import sample_coder_pkg::*;
#(
   parameter int SAMPLE_W = 10
) (
   input  logic [CODE_W-1:0]   fmt,
   input  logic [SAMPLE_W-1:0] bin,
   output logic [SAMPLE_W-1:0] coded
);
   localparam int MSB = SAMPLE_W - 1;

   logic [SAMPLE_W-1:0] gray;
   logic [SAMPLE_W-1:0] twos;

   assign gray[MSB] = bin[MSB];
   for (genvar i = 0; i < MSB; i++) begin : g_gray
      assign gray[i] = bin[i] ^ bin[i+1];
   end

   assign twos = {~bin[MSB], bin[MSB-1:0]};

   always_comb begin
      case (fmt)
         FMT_TWOS: coded = twos;
         FMT_GRAY: coded = gray;
         default:  coded = bin;
      endcase
   end
endmodule

// File: rtl/sample_coder.sv
module sample_coder
   import sample_coder_pkg::*;
#(
   parameter int SAMPLE_W = 10,
   parameter int CFG_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst_n,
   input  logic                cfg_we,
   input  logic [CFG_W-1:0]    cfg_wdata,
   input  logic [1:0]          fmt_strap,
   input  logic [1:0]          mode_strap,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic [1:0]          out_mode
);
   localparam logic [SAMPLE_W-1:0] MSB_MASK = {1'b1, {(SAMPLE_W-1){1'b0}}};

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("sample_coder: SAMPLE_W must be at least 2");
   end
   if (CFG_W != 8) begin : g_bad_cfg
      $error("sample_coder: CFG_W must be 8");
   end

   logic [FIELD_W-1:0]  fmt_field;
   logic [FIELD_W-1:0]  mode_field;
   logic [CODE_W-1:0]   fmt_code;
   logic [SAMPLE_W-1:0] coded;

   sc_cfg_reg #(.DATA_W(CFG_W), .FMT_LSB(0), .MODE_LSB(5)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .wdata      (cfg_wdata),
      .fmt_field  (fmt_field),
      .mode_field (mode_field)
   );

   sc_field_sel #(.CODE_B0(FMT_TWOS), .CODE_B1(FMT_GRAY), .CODE_B2(FMT_OFFSET)) u_fmt_sel (
      .field (fmt_field),
      .strap (fmt_strap),
      .code  (fmt_code)
   );

   sc_field_sel #(.CODE_B0(MODE_LVDS_LO), .CODE_B1(MODE_LVDS_HI), .CODE_B2(MODE_CMOS)) u_mode_sel (
      .field (mode_field),
      .strap (mode_strap),
      .code  (out_mode)
   );

   sc_recode #(.SAMPLE_W(SAMPLE_W)) u_recode (
      .fmt   (fmt_code),
      .bin   (in_sample),
      .coded (coded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else if (!soft_rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sample <= coded;
      end
   end

   assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(soft_rst_n)) |-> (out_valid == $past(in_valid)));

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(soft_rst_n) && !$past(in_valid)) |-> $stable(out_sample));

   assert_twos_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(soft_rst_n) && $past(in_valid) && $past(fmt_code) == FMT_TWOS)
      |-> (out_sample == ($past(in_sample) ^ MSB_MASK)));

   assert_gray_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(soft_rst_n) && $past(in_valid) && $past(fmt_code) == FMT_GRAY)
      |-> (out_sample == ($past(in_sample) ^ ($past(in_sample) >> 1))));

   assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_mode != 2'b11);

   assert_soft_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst_n |=> (!out_valid && out_sample == '0));

   assert_cfg_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(soft_rst_n) && !$past(cfg_we))
      |-> ($stable(fmt_field) && $stable(mode_field)));
endmodule

// File: tb/sample_coder_tb.sv
module sample_coder_tb;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         soft_rst_n = 1'b1;
   logic         cfg_we = 1'b0;
   logic [7:0]   cfg_wdata = '0;
   logic [1:0]   fmt_strap = 2'b00;
   logic [1:0]   mode_strap = 2'b00;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_sample = '0;
   logic         out_valid;
   logic [W-1:0] out_sample;
   logic [1:0]   out_mode;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   sample_coder #(.SAMPLE_W(W), .CFG_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .fmt_strap(fmt_strap), .mode_strap(mode_strap),
      .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(out_valid), .out_sample(out_sample), .out_mode(out_mode)
   );

   function automatic logic [W-1:0] to_twos(logic [W-1:0] b);
      return b ^ (1 << (W-1));
   endfunction
   function automatic logic [W-1:0] to_gray(logic [W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_cfg(logic [7:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // presents one sample, returns at the negedge after it is registered
   task automatic send(logic [W-1:0] s);
      in_valid = 1'b1; in_sample = s;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 out_valid", {31'd0, out_valid}, 0);
      check("R1 out_sample", {22'd0, out_sample}, 0);
      check("R1/R7 mode from strap", {30'd0, out_mode}, 0);
   endtask

   task automatic t_strap_fmt;
      logic [W-1:0] s = 10'h2C5;
      fmt_strap = 2'b00; send(s); check("R5 strap 00 offset", {22'd0, out_sample}, {22'd0, s});
      check("R8 out_valid high", {31'd0, out_valid}, 1);
      fmt_strap = 2'b01; send(s); check("R5 strap 01 twos", {22'd0, out_sample}, {22'd0, to_twos(s)});
      fmt_strap = 2'b10; send(s); check("R5 strap 10 gray", {22'd0, out_sample}, {22'd0, to_gray(s)});
      fmt_strap = 2'b11; send(s); check("R5 strap 11 offset", {22'd0, out_sample}, {22'd0, s});
   endtask

   task automatic t_reg_fmt;
      logic [W-1:0] s = 10'h137;
      fmt_strap = 2'b10;
      write_cfg(8'h01); send(s); check("R2 twos", {22'd0, out_sample}, {22'd0, to_twos(s)});
      send(10'h000); check("R2 twos zero", {22'd0, out_sample}, {22'd0, 10'h200});
      write_cfg(8'h02); send(s); check("R3 gray", {22'd0, out_sample}, {22'd0, to_gray(s)});
      send(10'h3FF); check("R3 gray full", {22'd0, out_sample}, {22'd0, 10'h200});
      write_cfg(8'h04); send(s); check("R4 offset", {22'd0, out_sample}, {22'd0, s});
      write_cfg(8'h03); send(s); check("R5 non-one-hot uses strap", {22'd0, out_sample}, {22'd0, to_gray(s)});
      write_cfg(8'h00); fmt_strap = 2'b01; send(s);
      check("R5 zero field uses strap", {22'd0, out_sample}, {22'd0, to_twos(s)});
   endtask

   task automatic t_mode;
      mode_strap = 2'b10;
      write_cfg(8'h20); #1 check("R6 mode 001", {30'd0, out_mode}, 0);
      write_cfg(8'h40); #1 check("R6 mode 010", {30'd0, out_mode}, 1);
      write_cfg(8'h80); #1 check("R6 mode 100", {30'd0, out_mode}, 2);
      write_cfg(8'hE0); #1 check("R7 non-one-hot mode strap 10", {30'd0, out_mode}, 2);
      write_cfg(8'h00);
      mode_strap = 2'b00; #1 check("R7 strap 00", {30'd0, out_mode}, 0);
      mode_strap = 2'b01; #1 check("R7 strap 01", {30'd0, out_mode}, 1);
      mode_strap = 2'b11; #1 check("R7 strap 11", {30'd0, out_mode}, 0);
   endtask

   task automatic t_hold;
      logic [W-1:0] s = 10'h0A3;
      write_cfg(8'h04); send(s);
      in_sample = 10'h3C3; @(negedge clk);
      check("R8 valid low after idle", {31'd0, out_valid}, 0);
      check("R8 hold when idle", {22'd0, out_sample}, {22'd0, s});
   endtask

   task automatic t_soft;
      logic [W-1:0] s = 10'h155;
      write_cfg(8'h42); send(s);
      in_valid = 1'b1; soft_rst_n = 1'b0; @(negedge clk);
      in_valid = 1'b0; soft_rst_n = 1'b1;
      check("R9 soft clears valid", {31'd0, out_valid}, 0);
      check("R9 soft clears sample", {22'd0, out_sample}, 0);
      check("R9 mode kept", {30'd0, out_mode}, 1);
      send(s); check("R9 format kept", {22'd0, out_sample}, {22'd0, to_gray(s)});
   endtask

   task automatic t_timing;
      logic [W-1:0] s1 = 10'h2F0;
      logic [W-1:0] s2 = 10'h0F1;
      write_cfg(8'h04);
      cfg_we = 1'b1; cfg_wdata = 8'h01; in_valid = 1'b1; in_sample = s1;
      @(negedge clk);
      cfg_we = 1'b0; in_sample = s2;
      check("R10 same-cycle sample uses old", {22'd0, out_sample}, {22'd0, s1});
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 next sample uses new", {22'd0, out_sample}, {22'd0, to_twos(s2)});
   endtask

   task automatic t_hard;
      write_cfg(8'h82);
      rst_n = 1'b0; #1;
      check("R1 hard reset clears valid", {31'd0, out_valid}, 0);
      @(negedge clk); rst_n = 1'b1;
      fmt_strap = 2'b00; mode_strap = 2'b01;
      send(10'h155);
      check("R1 register cleared fmt", {22'd0, out_sample}, {22'd0, 10'h155});
      check("R1 register cleared mode", {30'd0, out_mode}, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_strap_fmt;
      t_reg_fmt;
      t_mode;
      t_hold;
      t_soft;
      t_timing;
      t_hard;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule